// File: doc/BRIEF.md
# Shared Packed-Integer / Extended-Float Register Bank

This block holds eight 80-bit extended-precision registers that two execution views share. A packed-integer view sees each register as a 64-bit value: it has one write port and two read ports, and it addresses registers directly by number 0..7. A floating-point view sees the same storage as a stack. It addresses entries relative to a 3-bit top pointer, which push and pop commands move. Both views use one physical array, so a write through either view is visible through the other. A packed-integer write always forces the upper 16 bits of the entry to all ones, so floating-point code that reads such an entry sees a NaN or infinity pattern.

A small state machine tracks which view owns the bank. It has two states. In `MODE_FP` the bank behaves as a float stack. `MODE_SIMD` is entered on the transition *enter_simd*, which any packed-integer write without a same-cycle exit command triggers. It leaves on the transition *exit_simd*, which the exit command triggers and which hands the bank back to float code with every tag marked empty. A raw port reads any full 80-bit entry by physical number, so a context switch can save the bank.

Top module: `shared_vec_fp_bank`

## Requirements
- R1: After reset the top pointer is 0, every tag bit is 0 (empty), the mode output is 0 (`MODE_FP`) and every entry reads zero on the raw port.
- R2: A packed-integer write to register n stores the 64-bit data in bits 63:0 of physical entry n and 16'hFFFF in bits 79:64. The new value appears on the raw port in the next cycle.
- R3: Each packed-integer read port returns bits 63:0 of the physical entry its index selects, whatever the value of the top pointer.
- R4: A float write with offset k writes the full 80 bits to physical entry (top+k) mod 8 and sets tag bit (top+k) mod 8. A float read with offset k returns the full entry at (top+k) mod 8. Tag bit i belongs to physical entry i, and 1 means valid.
- R5: Push alone makes top = top-1 mod 8 and pop alone makes top = top+1 mod 8. Push and pop in the same cycle leave top unchanged. Pop alone clears the tag bit of the entry at the old top.
- R6: A packed-integer write without an exit command moves the state machine to `MODE_SIMD` (mode output 1), sets top to 0 and sets all eight tag bits.
- R7: The exit command moves the state machine to `MODE_FP` and clears all eight tag bits. It leaves stored data and top unchanged, except that a same-cycle packed-integer write still stores its data and zeroes top.
- R8: All read ports are combinational. A read of an entry that is being written in the same cycle returns the old value.
- R9: A packed-integer write overrides float activity in the same cycle. It wins over a float write to the same physical entry, and its top reset wins over push and pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vec_we | input | 1 | Packed-integer write enable |
| vec_widx | input | 3 | Packed-integer write register number |
| vec_wdata | input | 64 | Packed-integer write data |
| vec_ridx_a | input | 3 | Read port A register number |
| vec_rdata_a | output | 64 | Read port A data |
| vec_ridx_b | input | 3 | Read port B register number |
| vec_rdata_b | output | 64 | Read port B data |
| flt_push | input | 1 | Decrement top pointer |
| flt_pop | input | 1 | Increment top pointer, clear old top tag |
| flt_we | input | 1 | Float write enable |
| flt_woff | input | 3 | Float write offset from top |
| flt_wdata | input | 80 | Float write data |
| flt_roff | input | 3 | Float read offset from top |
| flt_rdata | output | 80 | Float read data |
| leave_simd | input | 1 | Exit packed-integer mode command |
| raw_idx | input | 3 | Raw read physical entry number |
| raw_rdata | output | 80 | Raw read data |
| stk_top | output | 3 | Current top pointer |
| tag_valid | output | 8 | Tag bits, bit i for entry i |
| simd_mode | output | 1 | 1 when in MODE_SIMD |

## Verification
If the top pointer goes wrong, every float read and write lands on the wrong entry. This shows up on the float read port and on the raw port in the cycle after the bad update. A missing forced exponent, or a write-port priority error, shows on the raw port one cycle after the write. Tag or mode errors appear on `tag_valid` and `simd_mode` in the cycle after a packed-integer write, an exit command or a pop. Read-before-write errors show in the write cycle itself, because the reads are combinational.

// File: rtl/shared_bank_pkg.sv
package shared_bank_pkg;
    typedef enum logic {
        MODE_FP   = 1'b0,
        MODE_SIMD = 1'b1
    } bank_mode_e;
endpackage

// File: rtl/bank_storage.sv
module bank_storage #(
    parameter int N_REG = 8,
    parameter int INT_W = 64,
    parameter int EXT_W = 80,
    localparam int IW   = $clog2(N_REG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vec_we,
    input  logic [IW-1:0]    vec_widx,
    input  logic [INT_W-1:0] vec_wdata,
    input  logic             flt_we,
    input  logic [IW-1:0]    flt_wphys,
    input  logic [EXT_W-1:0] flt_wdata,
    output logic [EXT_W-1:0] entry_o [N_REG]
);
    localparam int HI_W = EXT_W - INT_W;

    logic [EXT_W-1:0] mem_q [N_REG];

    for (genvar gi = 0; gi < N_REG; gi++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem_q[gi] <= '0;
            end else if (vec_we && vec_widx == IW'(gi)) begin
                mem_q[gi] <= {{HI_W{1'b1}}, vec_wdata};
            end else if (flt_we && flt_wphys == IW'(gi)) begin
                mem_q[gi] <= flt_wdata;
            end
        end
        assign entry_o[gi] = mem_q[gi];
    end

    // R2
    vec_hi_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_we |=> (mem_q[$past(vec_widx)][EXT_W-1:INT_W] == {HI_W{1'b1}}
                    && mem_q[$past(vec_widx)][INT_W-1:0] == $past(vec_wdata)));

    // R9
    vec_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_we && flt_we && vec_widx == flt_wphys)
        |=> mem_q[$past(vec_widx)][INT_W-1:0] == $past(vec_wdata));
endmodule

// File: rtl/bank_ctrl.sv
module bank_ctrl
    import shared_bank_pkg::*;
#(
    parameter int N_REG = 8,
    localparam int IW   = $clog2(N_REG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vec_we,
    input  logic             leave_cmd,
    input  logic             flt_push,
    input  logic             flt_pop,
    input  logic             flt_we,
    input  logic [IW-1:0]    flt_wphys,
    output logic [IW-1:0]    top_o,
    output logic [N_REG-1:0] tag_o,
    output bank_mode_e       mode_o
);
    bank_mode_e       mode_q, mode_d;
    logic [IW-1:0]    top_q, top_d;
    logic [N_REG-1:0] tag_q, tag_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_FP;
            top_q  <= '0;
            tag_q  <= '0;
        end else begin
            mode_q <= mode_d;
            top_q  <= top_d;
            tag_q  <= tag_d;
        end
    end

    // next state and outputs
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_FP:   if (vec_we && !leave_cmd) mode_d = MODE_SIMD;
            MODE_SIMD: if (leave_cmd)            mode_d = MODE_FP;
            default:   mode_d = MODE_FP;
        endcase

        top_d = top_q;
        if (vec_we) begin
            top_d = '0;
        end else if (flt_push && !flt_pop) begin
            top_d = top_q - IW'(1);
        end else if (flt_pop && !flt_push) begin
            top_d = top_q + IW'(1);
        end

        tag_d = tag_q;
        if (leave_cmd) begin
            tag_d = '0;
        end else if (vec_we) begin
            tag_d = '1;
        end else begin
            if (flt_we)               tag_d[flt_wphys] = 1'b1;
            if (flt_pop && !flt_push) tag_d[top_q]     = 1'b0;
        end
    end

    assign top_o  = top_q;
    assign tag_o  = tag_q;
    assign mode_o = mode_q;

    // R6
    enter_simd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_we && !leave_cmd) |=> (tag_q == '1 && mode_q == MODE_SIMD && top_q == '0));

    // R7
    exit_simd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        leave_cmd |=> (tag_q == '0 && mode_q == MODE_FP));

    // R5
    push_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_push && !flt_pop && !vec_we) |=> top_q == $past(top_q) - IW'(1));

    // R5
    pop_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_pop && !flt_push && !vec_we) |=> top_q == $past(top_q) + IW'(1));
endmodule

// File: rtl/shared_vec_fp_bank.sv
module shared_vec_fp_bank
    import shared_bank_pkg::*;
#(
    parameter int N_REG = 8,
    parameter int INT_W = 64,
    parameter int EXT_W = 80,
    localparam int IW   = $clog2(N_REG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vec_we,
    input  logic [IW-1:0]    vec_widx,
    input  logic [INT_W-1:0] vec_wdata,
    input  logic [IW-1:0]    vec_ridx_a,
    output logic [INT_W-1:0] vec_rdata_a,
    input  logic [IW-1:0]    vec_ridx_b,
    output logic [INT_W-1:0] vec_rdata_b,
    input  logic             flt_push,
    input  logic             flt_pop,
    input  logic             flt_we,
    input  logic [IW-1:0]    flt_woff,
    input  logic [EXT_W-1:0] flt_wdata,
    input  logic [IW-1:0]    flt_roff,
    output logic [EXT_W-1:0] flt_rdata,
    input  logic             leave_simd,
    input  logic [IW-1:0]    raw_idx,
    output logic [EXT_W-1:0] raw_rdata,
    output logic [IW-1:0]    stk_top,
    output logic [N_REG-1:0] tag_valid,
    output logic             simd_mode
);
    logic [EXT_W-1:0] entry [N_REG];
    logic [IW-1:0]    top;
    logic [IW-1:0]    flt_wphys;
    logic [IW-1:0]    flt_rphys;
    bank_mode_e       mode;

    assign flt_wphys = top + flt_woff;
    assign flt_rphys = top + flt_roff;

    bank_ctrl #(.N_REG(N_REG)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .vec_we    (vec_we),
        .leave_cmd (leave_simd),
        .flt_push  (flt_push),
        .flt_pop   (flt_pop),
        .flt_we    (flt_we),
        .flt_wphys (flt_wphys),
        .top_o     (top),
        .tag_o     (tag_valid),
        .mode_o    (mode)
    );

    bank_storage #(.N_REG(N_REG), .INT_W(INT_W), .EXT_W(EXT_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .vec_we    (vec_we),
        .vec_widx  (vec_widx),
        .vec_wdata (vec_wdata),
        .flt_we    (flt_we),
        .flt_wphys (flt_wphys),
        .flt_wdata (flt_wdata),
        .entry_o   (entry)
    );

    assign vec_rdata_a = entry[vec_ridx_a][INT_W-1:0];
    assign vec_rdata_b = entry[vec_ridx_b][INT_W-1:0];
    assign flt_rdata   = entry[flt_rphys];
    assign raw_rdata   = entry[raw_idx];
    assign stk_top     = top;
    assign simd_mode   = (mode == MODE_SIMD);

    // R3
    vec_read_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_rdata_a == raw_rdata[INT_W-1:0] || vec_ridx_a != raw_idx);
endmodule

// File: tb/test_shared_vec_fp_bank.sv
module test_shared_vec_fp_bank;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        vec_we;
    logic [2:0]  vec_widx;
    logic [63:0] vec_wdata;
    logic [2:0]  vec_ridx_a, vec_ridx_b;
    logic [63:0] vec_rdata_a, vec_rdata_b;
    logic        flt_push, flt_pop, flt_we;
    logic [2:0]  flt_woff, flt_roff;
    logic [79:0] flt_wdata, flt_rdata;
    logic        leave_simd;
    logic [2:0]  raw_idx;
    logic [79:0] raw_rdata;
    logic [2:0]  stk_top;
    logic [7:0]  tag_valid;
    logic        simd_mode;

    always #10 clk = ~clk;

    shared_vec_fp_bank i_shared_vec_fp_bank (.*);

    typedef struct {
        int          obs;
        logic [79:0] exp;
        string       name;
    } sb_item_t;

    sb_item_t sbq[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    localparam int OB_RAW = 0, OB_A = 1, OB_B = 2, OB_FLT = 3,
                   OB_TOP = 4, OB_TAG = 5, OB_MODE = 6;

    localparam logic [79:0] VA = 80'h4001_1111_2222_3333_4444;
    localparam logic [79:0] VB = 80'hC002_5555_6666_7777_8888;
    localparam logic [79:0] VC = 80'h3FFF_9999_AAAA_BBBB_CCCC;
    localparam logic [63:0] VD = 64'hDEAD_BEEF_0123_4567;
    localparam logic [63:0] VE = 64'h0F0F_1E1E_2D2D_3C3C;
    localparam logic [79:0] VF = 80'h1234_5678_9ABC_DEF0_1357;
    localparam logic [63:0] VG = 64'hA5A5_5A5A_C3C3_3C3C;

    task automatic step();
        @(posedge clk);
        #2;
        vec_we = 0; vec_widx = 0; vec_wdata = 0;
        flt_push = 0; flt_pop = 0; flt_we = 0;
        flt_woff = 0; flt_roff = 0; flt_wdata = 0;
        leave_simd = 0;
    endtask

    task automatic expect_item(int obs, logic [79:0] exp, string name);
        sb_item_t it;
        it.obs = obs; it.exp = exp; it.name = name;
        sbq.push_back(it);
    endtask

    // monitor: compares queued items late in the same cycle
    initial begin
        forever begin
            @(posedge clk);
            #12;
            while (sbq.size() > 0) begin
                sb_item_t it;
                logic [79:0] act;
                it = sbq.pop_front();
                case (it.obs)
                    OB_RAW:  act = raw_rdata;
                    OB_A:    act = {16'h0, vec_rdata_a};
                    OB_B:    act = {16'h0, vec_rdata_b};
                    OB_FLT:  act = flt_rdata;
                    OB_TOP:  act = {77'h0, stk_top};
                    OB_TAG:  act = {72'h0, tag_valid};
                    default: act = {79'h0, simd_mode};
                endcase
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s actual=%h expected=%h", it.name, act, it.exp);
                end
            end
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0;
        vec_we = 0; vec_widx = 0; vec_wdata = 0;
        vec_ridx_a = 0; vec_ridx_b = 0;
        flt_push = 0; flt_pop = 0; flt_we = 0;
        flt_woff = 0; flt_roff = 0; flt_wdata = 0;
        leave_simd = 0; raw_idx = 0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1;

        // R1 reset state
        raw_idx = 3;
        expect_item(OB_TOP, 0, "R1 top");
        expect_item(OB_TAG, 0, "R1 tags");
        expect_item(OB_MODE, 0, "R1 mode");
        expect_item(OB_RAW, 0, "R1 raw entry");

        // float write at top 0 + push; read sees old value (R8)
        step();
        flt_we = 1; flt_woff = 0; flt_wdata = VA; flt_push = 1; flt_roff = 0;
        expect_item(OB_FLT, 0, "R8 float read old");

        step();
        raw_idx = 0;
        expect_item(OB_TOP, 7, "R5 push");
        expect_item(OB_TAG, 8'h01, "R4 tag set");
        expect_item(OB_RAW, VA, "R4 float write");
        flt_we = 1; flt_woff = 2; flt_wdata = VB; flt_roff = 1;
        expect_item(OB_FLT, VA, "R4 float read offset");

        step();
        vec_ridx_a = 1;
        expect_item(OB_TAG, 8'h03, "R4 tag second");
        expect_item(OB_A, {16'h0, VB[63:0]}, "R4 cross view read");
        flt_we = 1; flt_woff = 0; flt_wdata = VC;

        step();
        expect_item(OB_TAG, 8'h83, "R4 tag top");
        flt_pop = 1;

        step();
        expect_item(OB_TOP, 0, "R5 pop");
        expect_item(OB_TAG, 8'h03, "R5 pop clears tag");
        flt_push = 1; flt_pop = 1;

        step();
        expect_item(OB_TOP, 0, "R5 push and pop");
        vec_ridx_b = 5;
        vec_we = 1; vec_widx = 5; vec_wdata = VD; flt_push = 1;
        expect_item(OB_B, 0, "R8 vec read old");

        step();
        raw_idx = 5; vec_ridx_a = 5;
        expect_item(OB_RAW, {16'hFFFF, VD}, "R2 forced exponent");
        expect_item(OB_A, {16'h0, VD}, "R3 vec read");
        expect_item(OB_TOP, 0, "R9 vec beats push");
        expect_item(OB_TAG, 8'hFF, "R6 tags valid");
        expect_item(OB_MODE, 1, "R6 simd mode");
        flt_push = 1;

        step();
        expect_item(OB_TOP, 7, "R5 push in simd");
        expect_item(OB_A, {16'h0, VD}, "R3 ignores top");
        flt_roff = 6;
        expect_item(OB_FLT, {16'hFFFF, VD}, "R2 float view sees nan");
        vec_we = 1; vec_widx = 2; vec_wdata = VE;
        flt_we = 1; flt_woff = 3; flt_wdata = VF;

        step();
        raw_idx = 2;
        expect_item(OB_RAW, {16'hFFFF, VE}, "R9 vec beats float write");
        expect_item(OB_TOP, 0, "R6 top zero");
        leave_simd = 1;

        step();
        expect_item(OB_TAG, 0, "R7 tags empty");
        expect_item(OB_MODE, 0, "R7 fp mode");
        expect_item(OB_RAW, {16'hFFFF, VE}, "R7 data kept");
        flt_push = 1;

        step();
        expect_item(OB_TOP, 7, "R5 push after exit");
        leave_simd = 1; vec_we = 1; vec_widx = 4; vec_wdata = VG;

        step();
        raw_idx = 4;
        expect_item(OB_TAG, 0, "R7 exit beats write tags");
        expect_item(OB_MODE, 0, "R7 exit beats write mode");
        expect_item(OB_TOP, 0, "R7 write zeroes top");
        expect_item(OB_RAW, {16'hFFFF, VG}, "R7 write data kept");
        flt_push = 1;

        step();
        leave_simd = 1;

        step();
        expect_item(OB_TOP, 7, "R7 top unchanged by exit");
        expect_item(OB_MODE, 0, "R7 mode stays fp");

        step();
        step();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule